// File: doc/BRIEF.md
# CAN Bit Stuffing Codec

This block sits between the frame sequencer and the bit timing logic of a CAN controller. It has two bit-serial paths that share nothing but the clock and reset. The transmit path takes the unstuffed frame bits one at a time. After five bits of equal level it emits one bit of the opposite level, and while it sends that bit it stalls its upstream source. The receive path watches the bus bits, removes each inserted bit from the stream it passes on, and pulses an error when a sixth equal bit arrives where only a stuff bit may appear.

Each path moves only on its own one-cycle bit tick. Each path also has its own stuffing enable, which the frame sequencer drops for the fixed-form tail of the frame (ACK delimiter, end of frame, interframe space). While the enable is low, bits pass straight through and the run count is held cleared. The level 0 is dominant and 1 is recessive. Both paths use the same run tracker: a counter that restarts at one whenever the level changes, and that treats an inserted bit as the first bit of a new run.

Top module: `can_stuff_codec`

## Requirements
- R1: After reset, tx_out_valid, rx_out_valid and rx_stuff_err are 0, tx_in_ready is 1, and tx_out and rx_out hold the recessive level 1.
- R2: With transmit stuffing on and tx_in_ready high, a tick on tx_bit_tick puts tx_in on tx_out. tx_out_valid is 1 for exactly the one cycle after the tick and 0 at all other times.
- R3: After five equal bits have left the transmit path with stuffing on, tx_in_ready is 0. The next tick then emits the complement of those bits, and tx_in is not consumed; it is sent on the following tick.
- R4: The run counter restarts at one when the level changes, and an inserted stuff bit counts as the first bit of its run. A stuff bit of 1 followed by four data 1s therefore triggers a stuff bit of 0, on transmit and on receive alike.
- R5: With tx_stuff_en low, tx_in_ready stays 1 and every bit passes through unchanged, however long the run. The run count is cleared, so after stuffing is switched back on, five further equal bits are needed before the next stuff bit.
- R6: With receive stuffing on, a bit that follows five equal bits and has the opposite level is dropped. rx_out_valid stays 0 for that bit time. All other bits appear on rx_out with rx_out_valid high for the one cycle after the rx_bit_tick.
- R7: With receive stuffing on, a sixth equal bit raises rx_stuff_err for one cycle and is not delivered (rx_out_valid 0). The run count then restarts, so the next bit is delivered as an ordinary data bit.
- R8: With rx_stuff_en low, every received bit is delivered and rx_stuff_err stays 0, even during a long run of equal bits. The run count is cleared.
- R9: Without a bit tick, neither path changes its output or raises its valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit_tick | input | 1 | One-cycle pulse per transmit bit time |
| tx_stuff_en | input | 1 | Enables insertion of stuff bits on transmit |
| tx_in | input | 1 | Unstuffed frame bit from the upstream source |
| tx_in_ready | output | 1 | High when the next tick consumes tx_in; low while a stuff bit is due |
| tx_out | output | 1 | Stuffed bit toward the bus driver |
| tx_out_valid | output | 1 | One-cycle qualifier for a new tx_out bit |
| rx_bit_tick | input | 1 | One-cycle pulse at each receive sample point |
| rx_stuff_en | input | 1 | Enables stuff-bit removal and checking on receive |
| rx_in | input | 1 | Sampled bus bit |
| rx_out | output | 1 | Destuffed bit toward the frame parser |
| rx_out_valid | output | 1 | One-cycle qualifier for a delivered rx_out bit |
| rx_stuff_err | output | 1 | One-cycle pulse on a stuff-rule violation |

## Verification
The receive path is driven through a table that gives the tracker these inputs in turn:
- a dominant run of five followed by a legal recessive stuff bit, which shows dropping apart from delivery;
- four recessive bits after that stuff bit, which shows that the inserted bit starts a new run;
- a dominant run that reaches six, which shows the error and the restart after it;
- a recessive stretch with stuffing off, which shows pass-through apart from checking.

On the transmit path, directed runs of both levels show when the stall and the complement bit occur. A long recessive stretch with stuffing off, followed by a run of five once stuffing is back on, shows that the disable clears the count and does not merely hide it. Idle cycles without a tick show that neither path moves on its own.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

    // Default length of an allowed run of equal bits.
    parameter int unsigned STUFF_RUN_DEF = 5;

    // Classification of a received bit by the destuffer.
    typedef enum logic [1:0] {
        RXK_DATA  = 2'd0,
        RXK_STUFF = 2'd1,
        RXK_VIOL  = 2'd2
    } rx_kind_e;

endpackage

// File: rtl/stuff_run_tracker.sv
module stuff_run_tracker #(
    parameter int unsigned RUN_LEN = can_stuff_pkg::STUFF_RUN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,        // stuffing region active
    input  logic clr,       // restart the count (used on a violation)
    input  logic step,      // one bit passes through this cycle
    input  logic bit_in,    // level of that bit
    output logic at_limit,  // RUN_LEN equal bits have been seen
    output logic last_bit   // level of the most recent bit
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             last;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (!en || clr) begin
            trk_d.cnt = '0;
        end else if (step) begin
            if (trk_q.cnt != '0 && bit_in == trk_q.last) begin
                if (trk_q.cnt != LIMIT) begin
                    trk_d.cnt = trk_q.cnt + 1'b1;
                end
            end else begin
                trk_d.cnt = CNT_W'(1);
            end
        end
        if (step) begin
            trk_d.last = bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{cnt: '0, last: 1'b1};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign at_limit = (trk_q.cnt == LIMIT);
    assign last_bit = trk_q.last;

endmodule

// File: rtl/tx_stuffer.sv
module tx_stuffer #(
    parameter int unsigned RUN_LEN = can_stuff_pkg::STUFF_RUN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stuff_en,
    input  logic bit_in,
    output logic bit_ready,
    output logic bit_out,
    output logic bit_valid
);
    typedef struct packed {
        logic out;
        logic vld;
    } txo_t;

    txo_t txo_d, txo_q;
    logic limit_hit;
    logic prev_bit;
    logic stuff_due;
    logic sent_bit;

    stuff_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stuff_en),
        .clr      (1'b0),
        .step     (tick),
        .bit_in   (sent_bit),
        .at_limit (limit_hit),
        .last_bit (prev_bit)
    );

    assign stuff_due = stuff_en && limit_hit;
    assign sent_bit  = stuff_due ? ~prev_bit : bit_in;
    assign bit_ready = ~stuff_due;

    always_comb begin
        txo_d     = txo_q;
        txo_d.vld = tick;
        if (tick) begin
            txo_d.out = sent_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txo_q <= '{out: 1'b1, vld: 1'b0};
        end else begin
            txo_q <= txo_d;
        end
    end

    assign bit_out   = txo_q.out;
    assign bit_valid = txo_q.vld;

endmodule

// File: rtl/rx_destuffer.sv
module rx_destuffer #(
    parameter int unsigned RUN_LEN = can_stuff_pkg::STUFF_RUN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stuff_en,
    input  logic bit_in,
    output logic bit_out,
    output logic bit_valid,
    output logic stuff_err
);
    import can_stuff_pkg::*;

    typedef struct packed {
        logic out;
        logic vld;
        logic err;
    } rxo_t;

    rxo_t     rxo_d, rxo_q;
    rx_kind_e kind;
    logic     limit_hit;
    logic     prev_bit;
    logic     viol_now;

    stuff_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stuff_en),
        .clr      (viol_now),
        .step     (tick),
        .bit_in   (bit_in),
        .at_limit (limit_hit),
        .last_bit (prev_bit)
    );

    always_comb begin
        kind = RXK_DATA;
        if (stuff_en && limit_hit) begin
            kind = (bit_in == prev_bit) ? RXK_VIOL : RXK_STUFF;
        end
    end

    assign viol_now = tick && (kind == RXK_VIOL);

    always_comb begin
        rxo_d     = rxo_q;
        rxo_d.vld = tick && (kind == RXK_DATA);
        rxo_d.err = viol_now;
        if (tick && kind == RXK_DATA) begin
            rxo_d.out = bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxo_q <= '{out: 1'b1, vld: 1'b0, err: 1'b0};
        end else begin
            rxo_q <= rxo_d;
        end
    end

    assign bit_out   = rxo_q.out;
    assign bit_valid = rxo_q.vld;
    assign stuff_err = rxo_q.err;

endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec #(
    parameter int unsigned RUN_LEN = can_stuff_pkg::STUFF_RUN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_tick,
    input  logic tx_stuff_en,
    input  logic tx_in,
    output logic tx_in_ready,
    output logic tx_out,
    output logic tx_out_valid,
    input  logic rx_bit_tick,
    input  logic rx_stuff_en,
    input  logic rx_in,
    output logic rx_out,
    output logic rx_out_valid,
    output logic rx_stuff_err
);

    tx_stuffer #(.RUN_LEN(RUN_LEN)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tx_bit_tick),
        .stuff_en  (tx_stuff_en),
        .bit_in    (tx_in),
        .bit_ready (tx_in_ready),
        .bit_out   (tx_out),
        .bit_valid (tx_out_valid)
    );

    rx_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rx_bit_tick),
        .stuff_en  (rx_stuff_en),
        .bit_in    (rx_in),
        .bit_out   (rx_out),
        .bit_valid (rx_out_valid),
        .stuff_err (rx_stuff_err)
    );

endmodule

// File: rtl/can_stuff_codec_chk.sv
module can_stuff_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_bit_tick,
    input logic tx_stuff_en,
    input logic tx_in_ready,
    input logic tx_out,
    input logic tx_out_valid,
    input logic rx_bit_tick,
    input logic rx_stuff_en,
    input logic rx_out_valid,
    input logic rx_stuff_err
);

    // R2: a transmit bit only appears after a tick
    assert_tx_valid_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> $past(tx_bit_tick));

    // R3: a stalled tick emits the complement of the previous bit
    assert_tx_stuff_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_tick && tx_stuff_en && !tx_in_ready) |=> (tx_out_valid && (tx_out != $past(tx_out))));

    // R6: a received bit only appears after a sample tick
    assert_rx_valid_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> $past(rx_bit_tick));

    // R7: a violating bit is never delivered
    assert_rx_err_not_delivered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |-> !rx_out_valid);

    // R8: no stuff error outside the stuffed region
    assert_rx_no_err_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_tick && !rx_stuff_en) |=> !rx_stuff_err);

endmodule

bind can_stuff_codec can_stuff_codec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_bit_tick  (tx_bit_tick),
    .tx_stuff_en  (tx_stuff_en),
    .tx_in_ready  (tx_in_ready),
    .tx_out       (tx_out),
    .tx_out_valid (tx_out_valid),
    .rx_bit_tick  (rx_bit_tick),
    .rx_stuff_en  (rx_stuff_en),
    .rx_out_valid (rx_out_valid),
    .rx_stuff_err (rx_stuff_err)
);

// File: tb/can_stuff_codec_test.sv
module can_stuff_codec_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit_tick = 1'b0;
    logic tx_stuff_en = 1'b0;
    logic tx_in = 1'b1;
    logic tx_in_ready;
    logic tx_out;
    logic tx_out_valid;
    logic rx_bit_tick = 1'b0;
    logic rx_stuff_en = 1'b0;
    logic rx_in = 1'b1;
    logic rx_out;
    logic rx_out_valid;
    logic rx_stuff_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_stuff_codec uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_bit_tick  (tx_bit_tick),
        .tx_stuff_en  (tx_stuff_en),
        .tx_in        (tx_in),
        .tx_in_ready  (tx_in_ready),
        .tx_out       (tx_out),
        .tx_out_valid (tx_out_valid),
        .rx_bit_tick  (rx_bit_tick),
        .rx_stuff_en  (rx_stuff_en),
        .rx_in        (rx_in),
        .rx_out       (rx_out),
        .rx_out_valid (rx_out_valid),
        .rx_stuff_err (rx_stuff_err)
    );

    // Receive vectors: {req code[2:0], stuff_en, rx_in, exp_valid, exp_out, exp_err}
    // req code: 0 = R6, 1 = R4, 2 = R7, 3 = R8
    localparam int RX_N = 25;
    localparam logic [7:0] RX_VEC [0:RX_N-1] = '{
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},   // stuff bit dropped
        {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},   // stuff bit after stuff+4
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},   // sixth equal bit
        {3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // restart after violation
        {3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}    // count was cleared
    };

    function automatic string req_name(input logic [2:0] code);
        case (code)
            3'd0:    return "R6";
            3'd1:    return "R4";
            3'd2:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_tx(input logic en, input logic b,
                           output logic rdy, output logic o, output logic v);
        tx_stuff_en = en;
        tx_in       = b;
        #1;
        rdy = tx_in_ready;
        tx_bit_tick = 1'b1;
        @(negedge clk);
        tx_bit_tick = 1'b0;
        o = tx_out;
        v = tx_out_valid;
    endtask

    task automatic tx_expect(input string req, input logic en, input logic b,
                             input logic exp_rdy, input logic exp_out);
        logic rdy, o, v;
        send_tx(en, b, rdy, o, v);
        check(rdy == exp_rdy, req, "tx_in_ready", rdy, exp_rdy);
        check(v == 1'b1,      req, "tx_out_valid", v, 1);
        check(o == exp_out,   req, "tx_out", o, exp_out);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_out_valid == 1'b0, "R1", "tx_out_valid", tx_out_valid, 0);
        check(rx_out_valid == 1'b0, "R1", "rx_out_valid", rx_out_valid, 0);
        check(rx_stuff_err == 1'b0, "R1", "rx_stuff_err", rx_stuff_err, 0);
        check(tx_in_ready  == 1'b1, "R1", "tx_in_ready", tx_in_ready, 1);
        check(tx_out == 1'b1, "R1", "tx_out", tx_out, 1);
        check(rx_out == 1'b1, "R1", "rx_out", rx_out, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Receive table
        for (int i = 0; i < RX_N; i++) begin
            logic [7:0] vec;
            string      rq;
            vec = RX_VEC[i];
            rq  = req_name(vec[7:5]);
            rx_stuff_en = vec[4];
            rx_in       = vec[3];
            rx_bit_tick = 1'b1;
            @(negedge clk);
            rx_bit_tick = 1'b0;
            check(rx_out_valid == vec[2], rq, "rx_out_valid", rx_out_valid, vec[2]);
            check(rx_stuff_err == vec[0], rq, "rx_stuff_err", rx_stuff_err, vec[0]);
            if (vec[2]) begin
                check(rx_out == vec[1], rq, "rx_out", rx_out, vec[1]);
            end
        end

        // R2: five dominant bits pass unchanged
        for (int i = 0; i < 5; i++) tx_expect("R2", 1'b1, 1'b0, 1'b1, 1'b0);
        // R3: stall, complement emitted, held bit not yet consumed
        tx_expect("R3", 1'b1, 1'b0, 1'b0, 1'b1);
        // R4: stuff bit 1 starts the run; four more 1s trigger a 0
        for (int i = 0; i < 4; i++) tx_expect("R4", 1'b1, 1'b1, 1'b1, 1'b1);
        tx_expect("R4", 1'b1, 1'b1, 1'b0, 1'b0);
        // R3: held bit goes out on the following tick
        tx_expect("R3", 1'b1, 1'b1, 1'b1, 1'b1);
        // R5: long recessive run with stuffing off
        for (int i = 0; i < 7; i++) tx_expect("R5", 1'b0, 1'b1, 1'b1, 1'b1);
        // R5: count cleared, a full run of five is needed again
        for (int i = 0; i < 5; i++) tx_expect("R5", 1'b1, 1'b1, 1'b1, 1'b1);
        tx_expect("R5", 1'b1, 1'b1, 1'b0, 1'b0);

        // R9: no tick, no movement
        tx_in = 1'b1;
        rx_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tx_out_valid == 1'b0, "R9", "tx_out_valid", tx_out_valid, 0);
            check(rx_out_valid == 1'b0, "R9", "rx_out_valid", rx_out_valid, 0);
            check(tx_out == 1'b0, "R9", "tx_out", tx_out, 0);
            check(rx_stuff_err == 1'b0, "R9", "rx_stuff_err", rx_stuff_err, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule